// File: doc/BRIEF.md
# Serial Flash Read-Buffer Tracker

This block is the slave side of a serial flash read port. A host clocks in a read opcode and a 24-bit byte address, and the block streams bytes out of a 1 KiB buffer that firmware loads through a simple write port. Two opcodes are recognised: a plain read (0x03), where data follows the address at once, and a fast read (0x0B), where eight dummy clocks come first. Any other opcode is left unanswered until chip select rises again.

The block also follows how far a linear read has moved through the two 512-byte halves of the buffer. Firmware can then refill the half that was just drained. A one-cycle watermark pulse fires when the byte at a programmable index goes out. A one-cycle flip pulse fires when the last byte of a half goes out. A read that starts outside the first 1 KiB of address space, or that does not continue where the previous one stopped, is reported as a misuse. It raises an error pulse and a sticky flag and does not drive the refill events. The full 24-bit address of the last byte sent and a pulse at the end of every host transaction complete the firmware view.

The SPI pins are sampled by the system clock, which must run well above the serial clock. All events come out as single-cycle pulses in the system clock domain.

Top module: `spi_rb_top`

## Requirements
- R1: SPI mode 0 is used. MOSI is taken on the rising SCK edge and MISO changes on the falling edge, MSB first. Opcodes 0x03 and 0x0B start a read and are followed by a 24-bit address. Any other opcode keeps MISO at 0, raises no watermark, flip or error pulse, and leaves the last address unchanged.
- R2: For opcode 0x03, data bit 7 of the byte at buffer index address[9:0] appears on the falling edge that ends the last address bit. Bytes go out MSB first.
- R3: For opcode 0x0B, eight dummy clocks follow the address, and the first data bit appears on the falling edge that ends the eighth dummy clock.
- R4: After each byte the address grows by one. The buffer index wraps within 1 KiB while bits 23:10 keep counting. The last address output holds the full 24-bit address of the last byte sent.
- R5: In a tracked read, one watermark pulse is given when the byte whose index equals the threshold input is sent.
- R6: In a tracked read, one flip pulse is given when a byte with index bits [8:0] all ones is sent, which is once per half crossed.
- R7: A read whose start address has any bit above bit 9 set gives one error pulse and sets the sticky flag. That read gives no watermark or flip pulses.
- R8: Once any byte has been sent since reset, a read whose start address is not the last address plus one is handled like R7.
- R9: The sticky error flag stays set until err_clr is high. A new error in the same cycle wins.
- R10: One cs_done_pulse is given for each rising edge of chip select.
- R11: A firmware write with fw_we high stores fw_wdata at buffer index fw_idx, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_csb | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data |
| fw_we | input | 1 | Firmware buffer write strobe |
| fw_idx | input | 10 | Firmware buffer write index |
| fw_wdata | input | 8 | Firmware buffer write data |
| rd_threshold | input | 10 | Watermark buffer index |
| err_clr | input | 1 | Clears the sticky error flag |
| last_addr | output | 24 | Address of the last byte sent |
| wm_pulse | output | 1 | Watermark event |
| flip_pulse | output | 1 | Half-buffer crossed event |
| err_pulse | output | 1 | Address misuse event |
| err_sticky | output | 1 | Sticky address misuse flag |
| cs_done_pulse | output | 1 | Chip select released event |

## Verification
The bench carries a long linear read across the middle of the buffer. A design that tests the wrong index bits would give no flip pulse, or a flip on every byte. A read that starts just below the end of the buffer, after a gap, checks that the wrap returns buffer byte 0 while the last address keeps counting. It also checks that the crossing gives no flip, since a design that ignored the gap would wrongly fire one. A read that continues exactly from an address past 1 KiB shows that the window check is separate from the gap check. The threshold is placed inside that read so that a leaked watermark would be seen. An unknown opcode confirms that MISO stays low and that no state moves.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    localparam int ADDR_W    = 24;
    localparam int BUF_AW    = 10;
    localparam int BYTE_W    = 8;
    localparam int DUMMY_CYC = 8;

    localparam logic [BYTE_W-1:0] OP_READ = 8'h03;
    localparam logic [BYTE_W-1:0] OP_FAST = 8'h0B;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e      ph;
        logic        fast;
        logic [2:0]  bit_no;
    } proto_ctl_t;

    function automatic logic is_read_op(input logic [BYTE_W-1:0] op);
        return (op == OP_READ) || (op == OP_FAST);
    endfunction

    function automatic logic is_fast_op(input logic [BYTE_W-1:0] op);
        return op == OP_FAST;
    endfunction

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int            N       = 3,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
                s3 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign q[i]    = s2;
        assign rise[i] = s2 & ~s3;
        assign fall[i] = ~s2 & s3;
    end
endmodule

// File: rtl/spi_rb_mem.sv
module spi_rb_mem #(
    parameter int BUF_BITS = 10,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [BUF_BITS-1:0] widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [BUF_BITS-1:0] ridx,
    output logic [DATA_W-1:0]   rdata
);
    localparam int DEPTH = 1 << BUF_BITS;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    assign rdata = store[ridx];
endmodule

// File: rtl/spi_rb_proto.sv
module spi_rb_proto
    import spi_rb_pkg::*;
#(
    parameter int ADDR_BITS  = ADDR_W,
    parameter int BUF_BITS   = BUF_AW,
    parameter int DUMMY_CLKS = DUMMY_CYC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 csb_lvl,
    input  logic                 mosi_lvl,
    input  logic [BYTE_W-1:0]    buf_rdata,
    output logic [BUF_BITS-1:0]  buf_ridx,
    output logic                 miso,
    output logic                 start_v,
    output logic [ADDR_BITS-1:0] start_addr,
    output logic                 sent_v,
    output logic [ADDR_BITS-1:0] sent_addr
);
    localparam int CNT_MAX = (ADDR_BITS > DUMMY_CLKS) ? ADDR_BITS : DUMMY_CLKS;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;

    proto_ctl_t             ctl;
    logic [CNT_W-1:0]       cnt;
    logic [BYTE_W-1:0]      cmd_sr;
    logic [ADDR_BITS-1:0]   addr_sr;
    logic [ADDR_BITS-1:0]   cur_addr;
    logic [BYTE_W-1:0]      out_sr;

    logic [BYTE_W-1:0]      cmd_full;
    logic [ADDR_BITS-1:0]   addr_full;
    logic [ADDR_BITS-1:0]   load_addr;
    logic [ADDR_BITS-1:0]   next_addr;
    logic                   do_load;

    always_comb begin
        cmd_full  = {cmd_sr[BYTE_W-2:0], mosi_lvl};
        addr_full = {addr_sr[ADDR_BITS-2:0], mosi_lvl};
        load_addr = (ctl.ph == PH_ADDR) ? addr_full : addr_sr;
        next_addr = cur_addr + 1'b1;
        buf_ridx  = (ctl.ph == PH_DATA) ? next_addr[BUF_BITS-1:0]
                                        : load_addr[BUF_BITS-1:0];
        do_load   = 1'b0;
        if (sck_rise) begin
            if (ctl.ph == PH_ADDR && !ctl.fast && cnt == CNT_W'(ADDR_BITS - 1))
                do_load = 1'b1;
            if (ctl.ph == PH_DUMMY && cnt == CNT_W'(DUMMY_CLKS - 1))
                do_load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || csb_lvl) begin
            ctl        <= '{ph: PH_CMD, fast: 1'b0, bit_no: 3'd0};
            cnt        <= '0;
            cmd_sr     <= '0;
            addr_sr    <= '0;
            cur_addr   <= '0;
            out_sr     <= '0;
            miso       <= 1'b0;
            start_v    <= 1'b0;
            start_addr <= '0;
            sent_v     <= 1'b0;
            sent_addr  <= '0;
        end else begin
            start_v <= 1'b0;
            sent_v  <= 1'b0;
            if (sck_rise) begin
                case (ctl.ph)
                    PH_CMD: begin
                        cmd_sr <= cmd_full;
                        cnt    <= cnt + 1'b1;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            cnt      <= '0;
                            ctl.fast <= is_fast_op(cmd_full);
                            ctl.ph   <= is_read_op(cmd_full) ? PH_ADDR : PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        addr_sr <= addr_full;
                        cnt     <= cnt + 1'b1;
                        if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                            cnt    <= '0;
                            ctl.ph <= ctl.fast ? PH_DUMMY : PH_DATA;
                        end
                    end
                    PH_DUMMY: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
                            cnt    <= '0;
                            ctl.ph <= PH_DATA;
                        end
                    end
                    default: ;
                endcase
                if (do_load) begin
                    cur_addr   <= load_addr;
                    out_sr     <= buf_rdata;
                    start_v    <= 1'b1;
                    start_addr <= load_addr;
                end
            end else if (sck_fall && ctl.ph == PH_DATA) begin
                miso <= out_sr[BYTE_W-1];
                if (ctl.bit_no == 3'd7) begin
                    ctl.bit_no <= 3'd0;
                    out_sr     <= buf_rdata;
                    cur_addr   <= next_addr;
                    sent_v     <= 1'b1;
                    sent_addr  <= cur_addr;
                end else begin
                    ctl.bit_no <= ctl.bit_no + 3'd1;
                    out_sr     <= {out_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_rb_track.sv
module spi_rb_track #(
    parameter int ADDR_BITS = 24,
    parameter int BUF_BITS  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_v,
    input  logic [ADDR_BITS-1:0] start_addr,
    input  logic                 sent_v,
    input  logic [ADDR_BITS-1:0] sent_addr,
    input  logic                 csb_rise,
    input  logic [BUF_BITS-1:0]  threshold,
    input  logic                 err_clr,
    output logic [ADDR_BITS-1:0] last_addr,
    output logic                 wm_pulse,
    output logic                 flip_pulse,
    output logic                 err_pulse,
    output logic                 err_sticky,
    output logic                 cs_done_pulse
);
    localparam int HALF_BITS = BUF_BITS - 1;

    logic                 have_prev;
    logic                 tracked;
    logic [ADDR_BITS-1:0] expect_next;

    logic out_of_window;
    logic gap;
    logic misuse;

    always_comb begin
        out_of_window = |start_addr[ADDR_BITS-1:BUF_BITS];
        gap           = have_prev && (start_addr != expect_next);
        misuse        = start_v && (out_of_window || gap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev     <= 1'b0;
            tracked       <= 1'b0;
            expect_next   <= '0;
            last_addr     <= '0;
            wm_pulse      <= 1'b0;
            flip_pulse    <= 1'b0;
            err_pulse     <= 1'b0;
            err_sticky    <= 1'b0;
            cs_done_pulse <= 1'b0;
        end else begin
            wm_pulse      <= 1'b0;
            flip_pulse    <= 1'b0;
            err_pulse     <= misuse;
            cs_done_pulse <= csb_rise;
            if (start_v) tracked <= !(out_of_window || gap);
            if (sent_v) begin
                last_addr   <= sent_addr;
                expect_next <= sent_addr + 1'b1;
                have_prev   <= 1'b1;
                wm_pulse    <= tracked && (sent_addr[BUF_BITS-1:0] == threshold);
                flip_pulse  <= tracked && (&sent_addr[HALF_BITS-1:0]);
            end
            if (misuse)       err_sticky <= 1'b1;
            else if (err_clr) err_sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_rb_top.sv
module spi_rb_top
    import spi_rb_pkg::*;
#(
    parameter int ADDR_BITS  = ADDR_W,
    parameter int BUF_BITS   = BUF_AW,
    parameter int DUMMY_CLKS = DUMMY_CYC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_sck,
    input  logic                 spi_csb,
    input  logic                 spi_mosi,
    output logic                 spi_miso,
    input  logic                 fw_we,
    input  logic [BUF_BITS-1:0]  fw_idx,
    input  logic [BYTE_W-1:0]    fw_wdata,
    input  logic [BUF_BITS-1:0]  rd_threshold,
    input  logic                 err_clr,
    output logic [ADDR_BITS-1:0] last_addr,
    output logic                 wm_pulse,
    output logic                 flip_pulse,
    output logic                 err_pulse,
    output logic                 err_sticky,
    output logic                 cs_done_pulse
);
    localparam int PIN_N = 3;
    localparam int P_SCK = 0;
    localparam int P_CSB = 1;
    localparam int P_DIN = 2;

    logic [PIN_N-1:0] pin_q, pin_rise, pin_fall;
    logic [BUF_BITS-1:0]  ridx;
    logic [BYTE_W-1:0]    rdata;
    logic                 start_v, sent_v;
    logic [ADDR_BITS-1:0] start_addr, sent_addr;

    spi_rb_sync #(.N(PIN_N), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .d    ({spi_mosi, spi_csb, spi_sck}),
        .q    (pin_q),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    spi_rb_mem #(.BUF_BITS(BUF_BITS), .DATA_W(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (fw_we),
        .widx  (fw_idx),
        .wdata (fw_wdata),
        .ridx  (ridx),
        .rdata (rdata)
    );

    spi_rb_proto #(
        .ADDR_BITS (ADDR_BITS),
        .BUF_BITS  (BUF_BITS),
        .DUMMY_CLKS(DUMMY_CLKS)
    ) u_proto (
        .clk        (clk),
        .rst        (rst),
        .sck_rise   (pin_rise[P_SCK]),
        .sck_fall   (pin_fall[P_SCK]),
        .csb_lvl    (pin_q[P_CSB]),
        .mosi_lvl   (pin_q[P_DIN]),
        .buf_rdata  (rdata),
        .buf_ridx   (ridx),
        .miso       (spi_miso),
        .start_v    (start_v),
        .start_addr (start_addr),
        .sent_v     (sent_v),
        .sent_addr  (sent_addr)
    );

    spi_rb_track #(.ADDR_BITS(ADDR_BITS), .BUF_BITS(BUF_BITS)) u_track (
        .clk           (clk),
        .rst           (rst),
        .start_v       (start_v),
        .start_addr    (start_addr),
        .sent_v        (sent_v),
        .sent_addr     (sent_addr),
        .csb_rise      (pin_rise[P_CSB]),
        .threshold     (rd_threshold),
        .err_clr       (err_clr),
        .last_addr     (last_addr),
        .wm_pulse      (wm_pulse),
        .flip_pulse    (flip_pulse),
        .err_pulse     (err_pulse),
        .err_sticky    (err_sticky),
        .cs_done_pulse (cs_done_pulse)
    );
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk (
    input logic clk,
    input logic rst,
    input logic spi_csb,
    input logic spi_miso,
    input logic err_clr,
    input logic wm_pulse,
    input logic flip_pulse,
    input logic err_pulse,
    input logic err_sticky,
    input logic cs_done_pulse
);
    a_r1_miso_idle: assert property (@(posedge clk) disable iff (rst)
        (spi_csb && $past(spi_csb) && $past(spi_csb, 2) && $past(spi_csb, 3)
         && $past(spi_csb, 4)) |-> !spi_miso);

    a_r5_wm_single: assert property (@(posedge clk) disable iff (rst)
        wm_pulse |=> !wm_pulse);

    a_r6_flip_single: assert property (@(posedge clk) disable iff (rst)
        flip_pulse |=> !flip_pulse);

    a_r7_err_no_flip: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !flip_pulse);

    a_r7_err_sets_flag: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky);

    a_r9_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !err_clr) |=> err_sticky);

    a_r10_cs_single: assert property (@(posedge clk) disable iff (rst)
        cs_done_pulse |=> !cs_done_pulse);
endmodule

bind spi_rb_top spi_rb_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .spi_csb       (spi_csb),
    .spi_miso      (spi_miso),
    .err_clr       (err_clr),
    .wm_pulse      (wm_pulse),
    .flip_pulse    (flip_pulse),
    .err_pulse     (err_pulse),
    .err_sticky    (err_sticky),
    .cs_done_pulse (cs_done_pulse)
);

// File: tb/sim_spi_rb_top.sv
`timescale 1ns/1ps
module sim_spi_rb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0, spi_csb = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso;
    logic        fw_we = 1'b0;
    logic [9:0]  fw_idx = '0;
    logic [7:0]  fw_wdata = '0;
    logic [9:0]  rd_threshold = 10'h010;
    logic        err_clr = 1'b0;
    logic [23:0] last_addr;
    logic        wm_pulse, flip_pulse, err_pulse, err_sticky, cs_done_pulse;

    always #4 clk = ~clk;

    spi_rb_top u0 (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csb(spi_csb),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .fw_we(fw_we),
        .fw_idx(fw_idx), .fw_wdata(fw_wdata), .rd_threshold(rd_threshold),
        .err_clr(err_clr), .last_addr(last_addr), .wm_pulse(wm_pulse),
        .flip_pulse(flip_pulse), .err_pulse(err_pulse),
        .err_sticky(err_sticky), .cs_done_pulse(cs_done_pulse)
    );

    int total = 0;
    int bad = 0;
    int n_wm = 0, n_flip = 0, n_err = 0, n_cs = 0;
    logic [7:0] model [1024];
    logic [7:0] exp_q [$];
    logic [7:0] rx_q [$];
    string      tag_q [$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares received bytes with expected bytes in order
    always @(negedge clk) begin
        if (!rst) begin
            if (wm_pulse) n_wm++;
            if (flip_pulse) n_flip++;
            if (err_pulse) n_err++;
            if (cs_done_pulse) n_cs++;
        end
        while (exp_q.size() > 0 && rx_q.size() > 0) begin
            logic [7:0] e, g;
            string t;
            e = exp_q.pop_front();
            g = rx_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'd0, g}, {24'd0, e});
        end
    end

    task automatic xfer_bit(input logic b, output logic r);
        @(posedge clk); #1 spi_mosi = b;
        repeat (8) @(posedge clk);
        #1 r = spi_miso; spi_sck = 1'b1;
        repeat (8) @(posedge clk);
        #1 spi_sck = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        logic r;
        for (int i = n - 1; i >= 0; i--) xfer_bit(v[i], r);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b0, r);
            v[i] = r;
        end
    endtask

    // driver: issues a read and pushes expected bytes for the monitor
    task automatic spi_read(input logic [7:0] op, input logic [23:0] addr,
                            input int nbytes, input string req);
        logic [7:0] got;
        spi_csb = 1'b0;
        repeat (4) @(posedge clk);
        send_bits({24'd0, op}, 8);
        send_bits({8'd0, addr}, 24);
        if (op == 8'h0B) send_bits(32'd0, 8);
        for (int j = 0; j < nbytes; j++) begin
            logic [23:0] a;
            a = addr + 24'(j);
            exp_q.push_back(model[a[9:0]]);
            tag_q.push_back(req);
            recv_byte(got);
            rx_q.push_back(got);
        end
        repeat (4) @(posedge clk);
        #1 spi_csb = 1'b1;
        repeat (20) @(posedge clk);
        #1;
    endtask

    task automatic fw_write(input logic [9:0] i, input logic [7:0] d);
        @(posedge clk); #1 fw_we = 1'b1; fw_idx = i; fw_wdata = d;
        @(posedge clk); #1 fw_we = 1'b0;
        model[i] = d;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int wm0, fl0, er0, cs0;
        logic [7:0] got;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("reset last_addr", {8'd0, last_addr}, 32'd0);
        check("reset R9 sticky", {31'd0, err_sticky}, 32'd0);
        check("reset R1 miso", {31'd0, spi_miso}, 32'd0);

        for (int i = 0; i < 1024; i++) fw_write(10'(i), 8'((i * 37 + 11) ^ (i >> 3)));
        fw_write(10'd5, 8'hA5); // R11

        // R2 R10: plain read from 0
        wm0 = n_wm; fl0 = n_flip; er0 = n_err; cs0 = n_cs;
        spi_read(8'h03, 24'h000000, 4, "R2 read data");
        check("R4 last_addr after read", {8'd0, last_addr}, 32'h3);
        check("R10 one cs pulse", n_cs - cs0, 1);
        check("R8 first read no error", n_err - er0, 0);

        // R3 R11: fast read continuing
        er0 = n_err; cs0 = n_cs;
        spi_read(8'h0B, 24'h000004, 3, "R3 R11 fast read data");
        check("R3 last_addr", {8'd0, last_addr}, 32'h6);
        check("R8 linear continue no error", n_err - er0, 0);
        check("R10 cs pulse fast", n_cs - cs0, 1);

        // R5 watermark at 0x010
        wm0 = n_wm; fl0 = n_flip;
        spi_read(8'h03, 24'h000007, 16, "R5 data");
        check("R5 watermark count", n_wm - wm0, 1);
        check("R6 no flip before half", n_flip - fl0, 0);

        // R6 flip across 0x1FF
        wm0 = n_wm; fl0 = n_flip; er0 = n_err;
        spi_read(8'h03, 24'h000017, 491, "R6 data");
        check("R6 flip count", n_flip - fl0, 1);
        check("R5 no repeat watermark", n_wm - wm0, 0);
        check("R4 last_addr long", {8'd0, last_addr}, 32'h201);
        check("R6 no error", n_err - er0, 0);

        // R8 gap, also R4 wrap
        wm0 = n_wm; fl0 = n_flip; er0 = n_err;
        spi_read(8'h03, 24'h0003FE, 4, "R4 wrap data");
        check("R8 gap error pulse", n_err - er0, 1);
        check("R8 sticky set", {31'd0, err_sticky}, 32'd1);
        check("R8 no flip untracked", n_flip - fl0, 0);
        check("R4 last_addr wraps upward", {8'd0, last_addr}, 32'h401);

        // R9 clear
        @(posedge clk); #1 err_clr = 1'b1;
        @(posedge clk); #1 err_clr = 1'b0;
        @(posedge clk); #1;
        check("R9 sticky cleared", {31'd0, err_sticky}, 32'd0);

        // R7 out of window, linear continuation
        rd_threshold = 10'h003;
        wm0 = n_wm; fl0 = n_flip; er0 = n_err;
        spi_read(8'h03, 24'h000402, 3, "R7 data");
        check("R7 error pulse", n_err - er0, 1);
        check("R7 sticky", {31'd0, err_sticky}, 32'd1);
        check("R7 no watermark", n_wm - wm0, 0);
        check("R4 last_addr high", {8'd0, last_addr}, 32'h404);

        // R1 unknown opcode
        wm0 = n_wm; fl0 = n_flip; er0 = n_err; cs0 = n_cs;
        spi_csb = 1'b0;
        repeat (4) @(posedge clk);
        send_bits(32'h9F, 8);
        for (int k = 0; k < 3; k++) begin
            recv_byte(got);
            check("R1 unknown opcode miso low", {24'd0, got}, 32'd0);
        end
        repeat (4) @(posedge clk);
        #1 spi_csb = 1'b1;
        repeat (20) @(posedge clk);
        #1;
        check("R1 last_addr unchanged", {8'd0, last_addr}, 32'h404);
        check("R1 no events", (n_wm - wm0) + (n_flip - fl0) + (n_err - er0), 0);
        check("R10 cs pulse unknown", n_cs - cs0, 1);

        repeat (4) @(posedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule